// File: doc/BRIEF.md
# Interrupt Redirection Controller

This block gathers 24 external interrupt lines and turns each line that is pending and not masked into one delivery message for the processor-side interrupt controllers. A message carries the vector, the delivery mode, a logical/physical destination flag, the polarity, the trigger mode and an 8-bit destination. The block does not resolve the destination into a set of processors.

Software programs the block through two 32-bit locations. A selector register at offset 0x00 chooses an internal register. A data window at offset 0x10 reads or writes the chosen register. Each line has a 64-bit routing entry, reached as a low half and a high half. Index 0x00 is an identity byte and index 0x01 is a read-only version word. Entry n has its low half at index 0x10 + 2n and its high half at 0x11 + 2n.

A scanner takes the lowest-numbered eligible line and puts its message on a valid/ready output. The message stays there until it is accepted. An edge-mode line sends once per rising edge. A level-mode line follows its wire. While it stays high it sends once, and it sends again only after it drops and rises again, or after its entry is rewritten.

Top module: `irq_redir_ctrl`

## Requirements
- R1: After reset, every routing entry reads 0x00010000 in its low half and 0 in its high half, so only the mask bit is set. The selector and the identity byte read 0, no line is pending, and `msg_valid` is low.
- R2: Offset 0x00 reads back the 8-bit selector in bits 7:0 and returns 0 in bits 31:8. Offset 0x10 is the data window. Every other offset reads 0 and ignores writes.
- R3: With the selector at 0x00, the window reads the identity byte in bits 31:24 and 0 elsewhere. A write stores only bits 31:24.
- R4: Selector 0x01 reads 0x11 in bits 7:0 and (lines − 1) = 0x17 in bits 23:16, which gives 0x00170011. Selector 0x02 reads 0. Writes to both are ignored.
- R5: Selector 0x10 + 2n holds bits 31:0 of entry n, and 0x11 + 2n holds bits 63:32. A selector above the last entry (0x40 and up) reads 0 and ignores writes.
- R6: An entry with bit 16 (mask) set produces no message. A line that went pending while masked is sent once a write to its entry clears the mask.
- R7: With bit 15 = 0 (edge mode), a rising line sets its pending bit. A falling line has no effect. Delivery clears the bit, so one rising edge gives exactly one message.
- R8: With bit 15 = 1 (level mode), the pending bit follows the line. A line that drops before its message is taken sends nothing. A line held high sends once, and sends again after a write to its entry or after it falls and rises again.
- R9: The message fields come from the entry: vector from bits 7:0, mode from 10:8, logical flag from bit 11, polarity from bit 13, level flag from bit 15, and destination from bits 63:56. `msg_pin` gives the line number.
- R10: With mode 7, `msg_ext` is 1 and `msg_vector` is 0, so the vector must come from an outside legacy controller. With any other mode, `msg_ext` is 0.
- R11: When several lines are eligible, the lowest-numbered line is sent first.
- R12: While `msg_valid` is high and `msg_ready` is low, the message and `msg_valid` hold steady. Each handshake sends exactly one message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_pin | input | 24 | Interrupt lines, active high, synchronous to `clk` |
| msg_valid | output | 1 | A message is offered |
| msg_ready | input | 1 | The receiver takes the message |
| msg_pin | output | 5 | Line that raised the message |
| msg_vector | output | 8 | Vector, 0 in mode 7 |
| msg_mode | output | 3 | Delivery mode |
| msg_logical | output | 1 | Destination is logical |
| msg_polarity | output | 1 | Polarity bit of the entry |
| msg_level | output | 1 | Line is level-triggered |
| msg_dest | output | 8 | Destination byte |
| msg_ext | output | 1 | Vector must come from the legacy controller |

## Verification
The hardest case to reach is a level line that rises and falls while the output is stalled. Its message must then never appear. The bench first stalls the output by holding `msg_ready` low behind a message from an edge line. It then raises the level line for a few cycles and drops it before releasing `msg_ready`, and it checks that only the edge message is counted. It also re-arms a level line that is held high by writing only the low half of its entry. A write to both halves would re-arm the line twice, so a single half-write is the way to show that a rewrite gives exactly one extra message.

// File: rtl/irq_redir_pkg.sv
`timescale 1ns/1ps
package irq_redir_pkg;

    localparam int DATA_W  = 32;
    localparam int ENTRY_W = 64;

    // bus offsets
    localparam logic [7:0] OFS_SELECT = 8'h00;
    localparam logic [7:0] OFS_WINDOW = 8'h10;

    // selector values
    localparam logic [7:0] SEL_IDENT   = 8'h00;
    localparam logic [7:0] SEL_VERSION = 8'h01;
    localparam logic [7:0] SEL_TABLE   = 8'h10;
    localparam logic [7:0] VERSION_ID  = 8'h11;

    // entry fields
    localparam int F_VEC_LSB  = 0;
    localparam int F_MODE_LSB = 8;
    localparam int F_LOGICAL  = 11;
    localparam int F_POLARITY = 13;
    localparam int F_LEVEL    = 15;
    localparam int F_MASK     = 16;
    localparam int F_DEST_LSB = 56;

    localparam logic [2:0] MODE_EXTERNAL = 3'd7;
    localparam logic [ENTRY_W-1:0] ENTRY_RESET = 64'h0000_0000_0001_0000;

    typedef struct packed {
        logic       ext;
        logic       level;
        logic       polarity;
        logic       logical;
        logic [2:0] mode;
        logic [7:0] vector;
        logic [7:0] dest;
    } redir_msg_t;

    function automatic redir_msg_t decode_entry(input logic [ENTRY_W-1:0] e);
        redir_msg_t m;
        m.mode     = e[F_MODE_LSB +: 3];
        m.ext      = (m.mode == MODE_EXTERNAL);
        m.level    = e[F_LEVEL];
        m.polarity = e[F_POLARITY];
        m.logical  = e[F_LOGICAL];
        m.vector   = m.ext ? 8'h00 : e[F_VEC_LSB +: 8];
        m.dest     = e[F_DEST_LSB +: 8];
        return m;
    endfunction

endpackage

// File: rtl/irq_redir_regs.sv
`timescale 1ns/1ps
module irq_redir_regs
    import irq_redir_pkg::*;
#(
    parameter int NUM_PINS = 24
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bus_en,
    input  logic                              bus_wr,
    input  logic [7:0]                        bus_addr,
    input  logic [DATA_W-1:0]                 bus_wdata,
    output logic [DATA_W-1:0]                 bus_rdata,
    output logic [NUM_PINS-1:0][ENTRY_W-1:0]  tbl_o,
    output logic [NUM_PINS-1:0]               ent_wr_o
);

    localparam int ENT_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
    localparam logic [7:0] LAST_PIN = 8'(NUM_PINS - 1);

    typedef struct packed {
        logic [7:0]                       sel;
        logic [7:0]                       ident;
        logic [NUM_PINS-1:0][ENTRY_W-1:0] tbl;
    } regs_t;

    regs_t st_d, st_q;

    logic [6:0]       ent_num;
    logic [ENT_W-1:0] ent_sel;
    logic             ent_hit;
    logic             upper;
    logic             wr_sel;
    logic             wr_win;
    logic [DATA_W-1:0] win_val;

    always_comb begin
        // selector decode for the table window
        ent_num = st_q.sel[7:1] - 7'h08;
        ent_sel = ent_num[ENT_W-1:0];
        upper   = st_q.sel[0];
        ent_hit = (st_q.sel >= SEL_TABLE) && (int'(ent_num) < NUM_PINS);

        wr_sel = bus_en && bus_wr && (bus_addr == OFS_SELECT);
        wr_win = bus_en && bus_wr && (bus_addr == OFS_WINDOW);

        st_d     = st_q;
        ent_wr_o = '0;

        if (wr_sel) begin
            st_d.sel = bus_wdata[7:0];
        end
        if (wr_win) begin
            if (st_q.sel == SEL_IDENT) begin
                st_d.ident = bus_wdata[31:24];
            end else if (ent_hit) begin
                if (upper) begin
                    st_d.tbl[ent_sel][63:32] = bus_wdata;
                end else begin
                    st_d.tbl[ent_sel][31:0] = bus_wdata;
                end
                ent_wr_o[ent_sel] = 1'b1;
            end
        end

        // window read value
        win_val = '0;
        if (st_q.sel == SEL_IDENT) begin
            win_val = {st_q.ident, 24'h0};
        end else if (st_q.sel == SEL_VERSION) begin
            win_val = {8'h00, LAST_PIN, 8'h00, VERSION_ID};
        end else if (ent_hit) begin
            win_val = upper ? st_q.tbl[ent_sel][63:32] : st_q.tbl[ent_sel][31:0];
        end

        bus_rdata = '0;
        if (bus_addr == OFS_SELECT) begin
            bus_rdata = {24'h0, st_q.sel};
        end else if (bus_addr == OFS_WINDOW) begin
            bus_rdata = win_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sel   <= '0;
            st_q.ident <= '0;
            for (int i = 0; i < NUM_PINS; i++) begin
                st_q.tbl[i] <= ENTRY_RESET;
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign tbl_o = st_q.tbl;

endmodule

// File: rtl/irq_redir_pend.sv
`timescale 1ns/1ps
module irq_redir_pend #(
    parameter int NUM_PINS = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic [NUM_PINS-1:0] level_i,
    input  logic [NUM_PINS-1:0] ent_wr_i,
    input  logic [NUM_PINS-1:0] take_i,
    output logic [NUM_PINS-1:0] pend_o,
    output logic [NUM_PINS-1:0] sent_o
);

    typedef struct packed {
        logic [NUM_PINS-1:0] prev;
        logic [NUM_PINS-1:0] pend;
        logic [NUM_PINS-1:0] sent;
    } pend_t;

    pend_t st_d, st_q;
    logic [NUM_PINS-1:0] rise;

    always_comb begin
        rise      = pin_i & ~st_q.prev;
        st_d.prev = pin_i;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (level_i[i]) begin
                // level: pending tracks the wire; one send per high phase
                st_d.pend[i] = pin_i[i];
                st_d.sent[i] = pin_i[i] && !ent_wr_i[i] && (st_q.sent[i] || take_i[i]);
            end else begin
                // edge: set on a rising wire, clear when delivered
                st_d.pend[i] = (st_q.pend[i] && !take_i[i]) || rise[i];
                st_d.sent[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
    assign sent_o = st_q.sent;

endmodule

// File: rtl/irq_redir_scan.sv
`timescale 1ns/1ps
module irq_redir_scan
    import irq_redir_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int PIN_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_PINS-1:0]              cand_i,
    input  logic [NUM_PINS-1:0][ENTRY_W-1:0] tbl_i,
    input  logic                             msg_ready_i,
    output logic [NUM_PINS-1:0]              take_o,
    output logic                             msg_valid_o,
    output logic [PIN_W-1:0]                 msg_pin_o,
    output redir_msg_t                       msg_o
);

    typedef struct packed {
        logic             valid;
        logic [PIN_W-1:0] pin;
        redir_msg_t       msg;
    } scan_t;

    scan_t st_d, st_q;
    logic [PIN_W-1:0] pick;
    logic             any;
    logic             load;

    always_comb begin
        // lowest-numbered candidate wins
        pick = '0;
        for (int i = NUM_PINS - 1; i >= 0; i--) begin
            if (cand_i[i]) begin
                pick = PIN_W'(i);
            end
        end
        any  = |cand_i;
        load = any && (!st_q.valid || msg_ready_i);

        st_d   = st_q;
        take_o = '0;
        if (st_q.valid && msg_ready_i) begin
            st_d.valid = 1'b0;
        end
        if (load) begin
            st_d.valid   = 1'b1;
            st_d.pin     = pick;
            st_d.msg     = decode_entry(tbl_i[pick]);
            take_o[pick] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign msg_valid_o = st_q.valid;
    assign msg_pin_o   = st_q.pin;
    assign msg_o       = st_q.msg;

endmodule

// File: rtl/irq_redir_ctrl.sv
`timescale 1ns/1ps
module irq_redir_ctrl
    import irq_redir_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int PIN_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_en,
    input  logic                bus_wr,
    input  logic [7:0]          bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] irq_pin,
    output logic                msg_valid,
    input  logic                msg_ready,
    output logic [PIN_W-1:0]    msg_pin,
    output logic [7:0]          msg_vector,
    output logic [2:0]          msg_mode,
    output logic                msg_logical,
    output logic                msg_polarity,
    output logic                msg_level,
    output logic [7:0]          msg_dest,
    output logic                msg_ext
);

    logic [NUM_PINS-1:0][ENTRY_W-1:0] tbl;
    logic [NUM_PINS-1:0] ent_wr;
    logic [NUM_PINS-1:0] ent_mask;
    logic [NUM_PINS-1:0] ent_level;
    logic [NUM_PINS-1:0] pend;
    logic [NUM_PINS-1:0] sent;
    logic [NUM_PINS-1:0] cand;
    logic [NUM_PINS-1:0] take;
    redir_msg_t          msg;

    irq_redir_regs #(.NUM_PINS(NUM_PINS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tbl_o     (tbl),
        .ent_wr_o  (ent_wr)
    );

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_field
        assign ent_mask[g]  = tbl[g][F_MASK];
        assign ent_level[g] = tbl[g][F_LEVEL];
    end

    irq_redir_pend #(.NUM_PINS(NUM_PINS)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_i    (irq_pin),
        .level_i  (ent_level),
        .ent_wr_i (ent_wr),
        .take_i   (take),
        .pend_o   (pend),
        .sent_o   (sent)
    );

    assign cand = pend & ~sent & ~ent_mask;

    irq_redir_scan #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_scan (
        .clk         (clk),
        .rst_n       (rst_n),
        .cand_i      (cand),
        .tbl_i       (tbl),
        .msg_ready_i (msg_ready),
        .take_o      (take),
        .msg_valid_o (msg_valid),
        .msg_pin_o   (msg_pin),
        .msg_o       (msg)
    );

    assign msg_vector   = msg.vector;
    assign msg_mode     = msg.mode;
    assign msg_logical  = msg.logical;
    assign msg_polarity = msg.polarity;
    assign msg_level    = msg.level;
    assign msg_dest     = msg.dest;
    assign msg_ext      = msg.ext;

endmodule

// File: rtl/irq_redir_chk.sv
`timescale 1ns/1ps
module irq_redir_chk #(
    parameter int PIN_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       bus_addr,
    input logic [31:0]      bus_rdata,
    input logic             msg_valid,
    input logic             msg_ready,
    input logic [PIN_W-1:0] msg_pin,
    input logic [7:0]       msg_vector,
    input logic [2:0]       msg_mode,
    input logic [7:0]       msg_dest,
    input logic             msg_ext
);

    // R12: a stalled message is not withdrawn
    a_r12_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> msg_valid);

    // R12: a stalled message keeps its content
    a_r12_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> ($stable(msg_pin) && $stable(msg_vector)
                                       && $stable(msg_mode) && $stable(msg_dest)));

    // R10: the external flag marks exactly mode 7
    a_r10_ext_mode: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_ext == (msg_mode == 3'd7)));

    // R10: no vector travels with an external-vector message
    a_r10_ext_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_ext) |-> (msg_vector == 8'h00));

    // R2: unused offsets read zero
    a_r2_other_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != 8'h00 && bus_addr != 8'h10) |-> (bus_rdata == 32'h0));

    // R2: the selector occupies only the low byte
    a_r2_select_width: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 8'h00) |-> (bus_rdata[31:8] == 24'h0));

endmodule

bind irq_redir_ctrl irq_redir_chk #(.PIN_W(PIN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .msg_valid  (msg_valid),
    .msg_ready  (msg_ready),
    .msg_pin    (msg_pin),
    .msg_vector (msg_vector),
    .msg_mode   (msg_mode),
    .msg_dest   (msg_dest),
    .msg_ext    (msg_ext)
);

// File: tb/test_irq_redir_ctrl.sv
`timescale 1ns/1ps
module test_irq_redir_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [23:0] irq_pin = '0;
    logic        msg_valid;
    logic        msg_ready = 1'b1;
    logic [4:0]  msg_pin;
    logic [7:0]  msg_vector;
    logic [2:0]  msg_mode;
    logic        msg_logical, msg_polarity, msg_level, msg_ext;
    logic [7:0]  msg_dest;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    irq_redir_ctrl i_irq_redir_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_pin(irq_pin), .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_pin(msg_pin), .msg_vector(msg_vector), .msg_mode(msg_mode),
        .msg_logical(msg_logical), .msg_polarity(msg_polarity),
        .msg_level(msg_level), .msg_dest(msg_dest), .msg_ext(msg_ext)
    );

    // handshake log
    int         n_msg = 0;
    int         log_pin [32];
    logic [7:0] last_vec, last_dest;
    logic [2:0] last_mode;
    logic       last_log, last_pol, last_lvl, last_ext;
    int         last_pin;

    always @(posedge clk) begin
        if (rst_n && msg_valid && msg_ready) begin
            if (n_msg < 32) log_pin[n_msg] = int'(msg_pin);
            last_pin  = int'(msg_pin);
            last_vec  = msg_vector;
            last_mode = msg_mode;
            last_log  = msg_logical;
            last_pol  = msg_polarity;
            last_lvl  = msg_level;
            last_dest = msg_dest;
            last_ext  = msg_ext;
            n_msg     = n_msg + 1;
        end
    end

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp,
                         input string what);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic set_entry(input int n, input logic [31:0] lo, input logic [31:0] hi);
        bus_write(8'h00, 32'(8'h11 + 8'(2 * n)));
        bus_write(8'h10, hi);
        bus_write(8'h00, 32'(8'h10 + 8'(2 * n)));
        bus_write(8'h10, lo);
    endtask

    task automatic pulse(input int p);
        @(negedge clk); irq_pin[p] = 1'b1;
        @(negedge clk); @(negedge clk); irq_pin[p] = 1'b0;
    endtask

    // register access vectors: R2 offsets, R3 identity, R4 version, R5 table window
    typedef struct packed {
        logic        wr;
        logic [7:0]  ofs;
        logic [31:0] dat;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h00, 32'h0000_0000, 32'h0,          8'd3},
        '{1'b1, 8'h10, 32'hAB12_3456, 32'h0,          8'd3},
        '{1'b0, 8'h10, 32'h0,         32'hAB00_0000,  8'd3},
        '{1'b1, 8'h00, 32'h0000_0001, 32'h0,          8'd4},
        '{1'b1, 8'h10, 32'hFFFF_FFFF, 32'h0,          8'd4},
        '{1'b0, 8'h10, 32'h0,         32'h0017_0011,  8'd4},
        '{1'b1, 8'h00, 32'h0000_0002, 32'h0,          8'd4},
        '{1'b1, 8'h10, 32'hFFFF_FFFF, 32'h0,          8'd4},
        '{1'b0, 8'h10, 32'h0,         32'h0000_0000,  8'd4},
        '{1'b0, 8'h00, 32'h0,         32'h0000_0002,  8'd2},
        '{1'b1, 8'h20, 32'hDEAD_BEEF, 32'h0,          8'd2},
        '{1'b0, 8'h20, 32'h0,         32'h0000_0000,  8'd2},
        '{1'b0, 8'h00, 32'h0,         32'h0000_0002,  8'd2},
        '{1'b1, 8'h00, 32'h0000_003E, 32'h0,          8'd5},
        '{1'b1, 8'h10, 32'h0001_A5A5, 32'h0,          8'd5},
        '{1'b0, 8'h10, 32'h0,         32'h0001_A5A5,  8'd5},
        '{1'b1, 8'h00, 32'h0000_003F, 32'h0,          8'd5},
        '{1'b1, 8'h10, 32'h1234_5678, 32'h0,          8'd5},
        '{1'b0, 8'h10, 32'h0,         32'h1234_5678,  8'd5},
        '{1'b1, 8'h00, 32'h0000_0040, 32'h0,          8'd5},
        '{1'b1, 8'h10, 32'hFFFF_FFFF, 32'h0,          8'd5},
        '{1'b0, 8'h10, 32'h0,         32'h0000_0000,  8'd5},
        '{1'b1, 8'h00, 32'h0000_003E, 32'h0,          8'd5},
        '{1'b0, 8'h10, 32'h0,         32'h0001_A5A5,  8'd5}
    };

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        int base;

        idle(4);
        rst_n = 1'b1;
        idle(2);

        // R1: reset state
        check(1, 32'(msg_valid), 32'h0, "no message after reset");
        bus_read(8'h00, rd);            check(1, rd, 32'h0, "selector after reset");
        bus_read(8'h10, rd);            check(1, rd, 32'h0, "identity after reset");
        bus_write(8'h00, 32'h10);
        bus_read(8'h10, rd);            check(1, rd, 32'h0001_0000, "entry 0 low after reset");
        bus_write(8'h00, 32'h11);
        bus_read(8'h10, rd);            check(1, rd, 32'h0, "entry 0 high after reset");

        // R2 R3 R4 R5: vector table
        for (int k = 0; k < NV; k++) begin
            if (VECS[k].wr) begin
                bus_write(VECS[k].ofs, VECS[k].dat);
            end else begin
                bus_read(VECS[k].ofs, rd);
                check(int'(VECS[k].req), rd, VECS[k].exp, $sformatf("vector %0d", k));
            end
        end

        // R7 R9: edge line 3, fields from the entry
        set_entry(3, 32'h0000_2842, 32'h5C00_0000);
        base = n_msg;
        @(negedge clk); irq_pin[3] = 1'b1;
        idle(10);
        irq_pin[3] = 1'b0;
        idle(5);
        check(7, 32'(n_msg - base), 32'd1, "edge line sends once");
        check(9, 32'(last_pin), 32'd3, "message line");
        check(9, {24'h0, last_vec}, 32'h42, "message vector");
        check(9, {last_dest, 21'h0, last_mode}, {8'h5C, 24'h0}, "dest and mode");
        check(9, {28'h0, last_log, last_pol, last_lvl, last_ext}, 32'b1100, "flags");

        // R8: level line 5 held high, rewrite, re-assert
        set_entry(5, 32'h0000_8077, 32'h0100_0000);
        base = n_msg;
        @(negedge clk); irq_pin[5] = 1'b1;
        idle(10);
        check(8, 32'(n_msg - base), 32'd1, "level held high sends once");
        check(8, 32'(last_lvl), 32'd1, "level flag");
        bus_write(8'h00, 32'h1A);
        bus_write(8'h10, 32'h0000_8077);
        idle(6);
        check(8, 32'(n_msg - base), 32'd2, "rewrite re-arms level line");
        irq_pin[5] = 1'b0;
        idle(3);
        irq_pin[5] = 1'b1;
        idle(6);
        check(8, 32'(n_msg - base), 32'd3, "re-assert re-arms level line");
        irq_pin[5] = 1'b0;
        idle(3);

        // R6: masked edge line 7, then unmask
        set_entry(7, 32'h0001_0030, 32'h0);
        base = n_msg;
        pulse(7);
        idle(8);
        check(6, 32'(n_msg - base), 32'd0, "masked line silent");
        set_entry(7, 32'h0000_0030, 32'h0);
        idle(6);
        check(6, 32'(n_msg - base), 32'd1, "unmask sends pending line");
        check(6, {24'h0, last_vec}, 32'h30, "unmasked vector");

        // R10: external vector mode
        set_entry(9, 32'h0000_0799, 32'h0200_0000);
        pulse(9);
        idle(6);
        check(10, {23'h0, last_ext, last_vec}, 32'h100, "ext flag, vector zero");
        check(10, {29'h0, last_mode}, 32'd7, "ext mode");

        // R11 R12: two lines at once under back-pressure
        msg_ready = 1'b0;
        set_entry(2, 32'h0000_0022, 32'h0);
        set_entry(6, 32'h0000_0066, 32'h0);
        base = n_msg;
        @(negedge clk); irq_pin[2] = 1'b1; irq_pin[6] = 1'b1;
        idle(4);
        check(11, {31'h0, msg_valid}, 32'd1, "message offered");
        check(11, 32'(msg_pin), 32'd2, "lowest line first");
        idle(5);
        check(12, {19'h0, msg_pin, msg_vector}, {19'h0, 5'd2, 8'h22}, "stalled message stable");
        check(12, 32'(n_msg - base), 32'd0, "no handshake while stalled");
        msg_ready = 1'b1;
        idle(6);
        check(12, 32'(n_msg - base), 32'd2, "one message per handshake");
        check(11, 32'(log_pin[base]), 32'd2, "first line");
        check(11, 32'(log_pin[base + 1]), 32'd6, "second line");
        irq_pin[2] = 1'b0; irq_pin[6] = 1'b0;
        idle(3);

        // R8: level line drops while output is stalled
        msg_ready = 1'b0;
        base = n_msg;
        pulse(2);
        idle(2);
        irq_pin[5] = 1'b1;
        idle(3);
        irq_pin[5] = 1'b0;
        idle(3);
        msg_ready = 1'b1;
        idle(8);
        check(8, 32'(n_msg - base), 32'd1, "dropped level line sends nothing");
        check(8, 32'(log_pin[base]), 32'd2, "only the edge message");

        finish_run();
    end

endmodule